// File: doc/BRIEF.md
# Ten-bit serializer with internal wrap path

This block turns a stream of ten-bit words, already line-coded upstream, into a serial bit stream clocked by a single bit clock. A modulo-ten counter inside the block produces a one-cycle strobe once per word. The word presented on the parallel input is captured on the clock edge where that strobe is high. It is then shifted out least significant bit first. The next word follows its last bit with no idle slot.

A wrap selector sits behind the shifter. In normal mode the serial stream goes to the line output, and the receive-side serial input is taken from the external line input. In wrap mode the line output is held at logic 0, and the serial stream is routed into the receive-side input in place of the external line. The mode is sampled only at word boundaries, so a wrapped or transmitted word is never split between modes. Both serial outputs are registered, which gives a fixed latency of one bit time from capture to the first bit.

Top module: `ser10_loop_tx`

## Requirements
- R1: `byte_stb` is high for exactly one clock in every ten. After synchronous reset is released, it first rises at the end of the ninth clock edge.
- R2: `tx_word` is captured only on the edge where `byte_stb` is high. Changes to `tx_word` at any other time have no effect on the word being sent.
- R3: The captured word is sent unchanged, bit 0 first and bit 9 last, one bit per clock.
- R4: Bit 0 of a captured word appears on the serial output one clock after the capture edge. Bit k appears k clocks after bit 0.
- R5: Bit 0 of each word follows bit 9 of the previous word in the very next clock, with no idle bit between them.
- R6: In normal mode (`loop_en` = 0 when sampled), `line_out` carries the serial stream and `rx_serial` equals `line_in` delayed by one clock.
- R7: In wrap mode (`loop_en` = 1 when sampled), `line_out` is held at 0 and `rx_serial` carries the serial stream with the timing given in R4.
- R8: `loop_en` is sampled only on the capture edge. A change in the middle of a word does not alter the mode of that word's bits.
- R9: When `rst_n` is low at a clock edge, `line_out`, `rx_serial` and `byte_stb` are 0 after that edge, and the bit counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_word | input | 10 | Pre-coded word; bit 0 is sent first |
| loop_en | input | 1 | Wrap mode request, sampled at word boundaries |
| line_in | input | 1 | External serial input for the receive path |
| byte_stb | output | 1 | Word strobe; `tx_word` is captured on this edge |
| line_out | output | 1 | Serial line output; 0 in wrap mode |
| rx_serial | output | 1 | Serial input selected for the receive path |

## Verification
The checker tracks the mode from `loop_en` at each strobe. On every cycle it checks that the strobe recurs every ten clocks and never on two clocks in a row, that `line_out` stays 0 whenever the wrap mode applied, and that `rx_serial` repeats the previous `line_in` in normal mode. Bit order, the contents of each word, the latency to bit 0, the gapless joins between words and the ignoring of late `tx_word` and mid-word `loop_en` changes are shown only by the bench's scenarios. Those scenarios compare each serial slot against the word that was driven. The restart of the counter after reset is also checked there.

// File: rtl/ser10_pkg.sv
// Shared types for the ten-bit serializer.
// Assumes: nothing beyond a single bit-clock domain.
package ser10_pkg;
    // Routing of the serial stream for the current word.
    typedef enum logic {
        LINK_EXT  = 1'b0,   // stream to line, receive from external line
        LINK_WRAP = 1'b1    // line held low, stream wrapped to receive
    } link_mode_e;
endpackage

// File: rtl/ser10_bitcnt.sv
// Modulo-WORD_W bit counter producing the word strobe.
// Assumes: one count per bit clock; strobe marks the last bit slot.
module ser10_bitcnt #(
    parameter int WORD_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic word_stb
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance the bit position, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // Strobe during the last slot of each word.
    always_comb word_stb = (cnt_q == LAST);
endmodule

// File: rtl/ser10_shifter.sv
// Word latch and LSB-first shift register.
// Assumes: load is a one-cycle pulse once per WORD_W clocks.
module ser10_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              ser_bit
);
    logic [WORD_W-1:0] sreg_q;

    // Capture a new word on load, otherwise move the next bit into place.
    always_ff @(posedge clk) begin
        if (!rst_n)    sreg_q <= '0;
        else if (load) sreg_q <= word_in;
        else           sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
    end

    // The current bit slot always sits at position 0.
    always_comb ser_bit = sreg_q[0];
endmodule

// File: rtl/ser10_wrapsel.sv
// Wrap selector: routes the serial stream to the line or to the receive input.
// Assumes: mode_req is sampled only on word boundaries (load).
module ser10_wrapsel
    import ser10_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic mode_req,
    input  logic ser_bit,
    input  logic ext_in,
    output logic line_out,
    output logic rx_out
);
    link_mode_e mode_q;

    // Latch the routing mode at the start of each word.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= LINK_EXT;
        else if (load) mode_q <= mode_req ? LINK_WRAP : LINK_EXT;
    end

    // Register both serial outputs according to the mode of the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= 1'b0;
            rx_out   <= 1'b0;
        end else if (mode_q == LINK_WRAP) begin
            line_out <= 1'b0;
            rx_out   <= ser_bit;
        end else begin
            line_out <= ser_bit;
            rx_out   <= ext_in;
        end
    end
endmodule

// File: rtl/ser10_loop_tx.sv
// Top: ten-bit serializer with word strobe and internal wrap path.
// Assumes: tx_word is valid on the clock edge where byte_stb is high.
module ser10_loop_tx #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              loop_en,
    input  logic              line_in,
    output logic              byte_stb,
    output logic              line_out,
    output logic              rx_serial
);
    logic ser_bit;

    ser10_bitcnt #(.WORD_W(WORD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_stb (byte_stb)
    );

    ser10_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (byte_stb),
        .word_in (tx_word),
        .ser_bit (ser_bit)
    );

    ser10_wrapsel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (byte_stb),
        .mode_req (loop_en),
        .ser_bit  (ser_bit),
        .ext_in   (line_in),
        .line_out (line_out),
        .rx_out   (rx_serial)
    );
endmodule

// File: rtl/ser10_loop_tx_chk.sv
// Checker bound to ser10_loop_tx: strobe cadence and wrap routing.
// Assumes: observes ports only; keeps its own mode and slot trackers.
module ser10_loop_tx_chk #(
    parameter int WORD_W = 10
) (
    input logic clk,
    input logic rst_n,
    input logic byte_stb,
    input logic loop_en,
    input logic line_in,
    input logic line_out,
    input logic rx_serial
);
    localparam int CW = $clog2(WORD_W);

    logic [CW-1:0] slot_q;
    logic          wrap_q;
    logic          live_q;

    // Independent slot counter since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                           slot_q <= '0;
        else if (slot_q == CW'(WORD_W - 1))   slot_q <= '0;
        else                                  slot_q <= slot_q + 1'b1;
    end

    // Mode as seen at the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        wrap_q <= 1'b0;
        else if (byte_stb) wrap_q <= loop_en;
    end

    // Marks that the previous cycle was out of reset.
    always_ff @(posedge clk) begin
        live_q <= rst_n;
    end

    assert_strobe_cadence_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb == (slot_q == CW'(WORD_W - 1)));

    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);

    assert_line_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(wrap_q)) |-> !line_out);

    assert_rx_from_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(wrap_q)) |-> (rx_serial == $past(line_in)));
endmodule

bind ser10_loop_tx ser10_loop_tx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_stb  (byte_stb),
    .loop_en   (loop_en),
    .line_in   (line_in),
    .line_out  (line_out),
    .rx_serial (rx_serial)
);

// File: tb/ser10_loop_tx_bench.sv
module ser10_loop_tx_bench;
    localparam int TCK   = 10;
    localparam int NVEC  = 8;
    // {toggle loop_en mid-word, loop_en, word}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 10'h17C},
        {1'b1, 1'b0, 10'h283},
        {1'b0, 1'b1, 10'h3FF},
        {1'b1, 1'b1, 10'h000},
        {1'b0, 1'b0, 10'h2AA},
        {1'b0, 1'b1, 10'h155},
        {1'b1, 1'b0, 10'h1F0},
        {1'b1, 1'b1, 10'h30F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] tx_word = '0;
    logic       loop_en = 1'b0;
    logic       line_in = 1'b0;
    logic       byte_stb, line_out, rx_serial;

    int applied = 0;
    int miscompares = 0;
    logic li_seen = 1'b0;

    ser10_loop_tx u_ser10_loop_tx (
        .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .loop_en(loop_en),
        .line_in(line_in), .byte_stb(byte_stb), .line_out(line_out),
        .rx_serial(rx_serial)
    );

    always #(TCK/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: flip line_in, then land on the following falling edge.
    task automatic step();
        line_in = ~line_in;
        li_seen = line_in;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare one serial slot against the bench model.
    task automatic check_bit(input logic [9:0] w, input logic wrap, input int k);
        check("R3/R6/R7 line_out", line_out, wrap ? 1'b0 : w[k]);
        check("R3/R6/R7 rx_serial", rx_serial, wrap ? w[k] : li_seen);
    endtask

    task automatic count_to_strobe(input string tag);
        int n = 0;
        while (!byte_stb && n < 20) begin
            step();
            n++;
        end
        applied++;
        if (n != 9) begin
            miscompares++;
            $display("FAIL %s: strobe after %0d clocks, expected 9", tag, n);
        end
    endtask

    initial begin
        logic [9:0] pw;
        logic       pl;
        logic       have_prev;
        have_prev = 1'b0;
        pw = '0;
        pl = 1'b0;
        @(negedge clk);
        step();
        // R9: reset state
        check("R9 line_out", line_out, 1'b0);
        check("R9 rx_serial", rx_serial, 1'b0);
        check("R9 byte_stb", byte_stb, 1'b0);
        rst_n = 1'b1;
        count_to_strobe("R1 first strobe");

        for (int i = 0; i < NVEC; i++) begin
            logic [9:0] w;
            logic       l, tg;
            w  = VEC[i][9:0];
            l  = VEC[i][10];
            tg = VEC[i][11];
            tx_word = w;
            loop_en = l;
            step();                         // capture edge
            if (have_prev) check_bit(pw, pl, 9);   // R5: gapless join
            check("R1 strobe low after capture", byte_stb, 1'b0);
            tx_word = ~w;                   // R2: late change ignored
            for (int k = 0; k < 9; k++) begin
                step();
                check_bit(w, l, k);         // R4: bit0 one clock after capture
                if (k == 4 && tg) loop_en = ~l;     // R8: mid-word change
            end
            check("R1 strobe at last slot", byte_stb, 1'b1);
            pw = w;
            pl = l;
            have_prev = 1'b1;
        end
        tx_word = 10'h000;
        loop_en = 1'b0;
        step();
        check_bit(pw, pl, 9);

        // R9: reset in mid-word, then counter restarts
        step();
        step();
        step();
        rst_n = 1'b0;
        step();
        check("R9 mid reset line_out", line_out, 1'b0);
        check("R9 mid reset rx_serial", rx_serial, 1'b0);
        check("R9 mid reset byte_stb", byte_stb, 1'b0);
        rst_n = 1'b1;
        count_to_strobe("R9 counter restart");

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        #(TCK * 20000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule